// File: doc/BRIEF.md
# UART Handshake Register Front End

This block is the bus-facing register set of a simple serial port. It has no FIFOs. One 32-bit data word at word offset 0 holds the byte together with two handshake flags. The first flag reports that a received byte is waiting. The second reports that the transmitter can take a new byte. Software writes a 1 to a flag bit to act on it: a 1 in the receive flag acknowledges the held byte, and a 1 in the transmit flag hands the byte in bits 7:0 to the transmitter.

A second word at word offset 1 holds the configuration. It selects the interface role and carries two override bits that force the transmit and receive ready conditions on when no peer flow control is in use. A sticky overrun flag sits in the same word.

On the serial side the block drives a one-cycle load pulse and a byte to a transmit shifter, and it waits for that shifter's done pulse. From a receive shifter it takes a byte and a strobe.

Top module: `uhs_regs`

## Requirements
- R1: After reset the receive-valid flag (data bit 8) reads 0, transmit-ready (data bit 9) reads 1 while `tx_cts` is high, the control word reads 0, and `tx_load` is low.
- R2: A `rx_strobe` pulse captures `rx_byte`. From the next cycle the data word reads that byte in bits 7:0 with bit 8 set to 1.
- R3: Writing the data word with bit 8 = 1 clears the receive-valid flag. Writing it with bit 8 = 0 leaves the flag and the held byte unchanged.
- R4: Writing the data word with bit 9 = 1 while transmit-ready reads 1 produces `tx_load` high for exactly the next cycle, with `tx_byte` equal to write bits 7:0. Transmit-ready then reads 0 until a `tx_done` pulse.
- R5: Writing the data word with bit 9 = 0 never raises `tx_load` and leaves transmit-ready unchanged, whatever bits 7:0 hold.
- R6: Writing the data word with bit 9 = 1 while transmit-ready reads 0 is ignored: no `tx_load` is produced.
- R7: The control word (offset 0x04) stores the interface mode in bits 3:2 (1 = DTE, 2 = DCE), the transmit-ready override in bit 7 and the receive-ready override in bit 8. All other bits read 0 apart from bit 12. `if_mode` follows bits 3:2.
- R8: Transmit-ready = transmitter idle AND (`tx_cts` OR control bit 7).
- R9: `rx_rts` = NOT receive-valid OR control bit 8.
- R10: A strobe that arrives while a byte is held and not being acknowledged in the same cycle replaces the held byte and sets overrun (control bit 12). Writing the control word with bit 12 = 1 clears overrun.
- R11: A data write with both bit 8 and bit 9 set performs the acknowledge and the transmit launch in the same cycle.
- R12: A strobe in the same cycle as an acknowledge leaves the new byte held with valid = 1 and does not set overrun.
- R13: Reads at word offsets other than 0 and 1 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address, word aligned |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data, combinational with default parameters |
| tx_byte | output | DATA_W (8) | Byte handed to the transmit shifter |
| tx_load | output | 1 | One-cycle launch pulse to the transmit shifter |
| tx_done | input | 1 | Transmit shifter finished its byte |
| tx_cts | input | 1 | Peer permits sending |
| rx_byte | input | DATA_W (8) | Byte from the receive shifter |
| rx_strobe | input | 1 | Receive byte valid pulse |
| rx_rts | output | 1 | Ready to receive, to the peer |
| if_mode | output | 2 | Selected interface role |

## Verification
State changes caused by a write, a strobe or a done pulse take effect at the clock edge that samples them. The register read path is combinational, so the effect shows on `bus_rdata` in the very next cycle. `tx_load` and `tx_byte` are registered and are valid exactly in the cycle after the write edge. The bench drives on the falling edge and samples `tx_load` on the falling edge that follows the write. It reads registers only after the stimulus has been removed. `tx_cts` and the override bits act on ready combinationally, so those checks follow immediately.

// File: rtl/uhs_pkg.sv
package uhs_pkg;
   // word offsets (byte address >> 2)
   localparam int unsigned WOFS_DATA = 0;
   localparam int unsigned WOFS_CTRL = 1;
   // data word flag positions
   localparam int unsigned DB_RXV    = 8;
   localparam int unsigned DB_TXR    = 9;
   // control word field positions
   localparam int unsigned CB_MODE   = 2;
   localparam int unsigned CB_TXOVR  = 7;
   localparam int unsigned CB_RXOVR  = 8;
   localparam int unsigned CB_OVRUN  = 12;
   localparam int unsigned MIN_BUS_W = CB_OVRUN + 1;

   typedef enum logic [1:0] {
      ROLE_NONE = 2'd0,
      ROLE_DTE  = 2'd1,
      ROLE_DCE  = 2'd2,
      ROLE_RSV  = 2'd3
   } role_e;

   typedef struct packed {
      logic  rx_force;
      logic  tx_force;
      role_e role;
   } cfg_t;
endpackage

// File: rtl/uhs_ctrl_reg.sv
module uhs_ctrl_reg
   import uhs_pkg::*;
#(
   parameter int unsigned BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wdata,
   output cfg_t             cfg,
   output logic             ovr_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.role     <= role_e'(wdata[CB_MODE +: 2]);
         cfg.tx_force <= wdata[CB_TXOVR];
         cfg.rx_force <= wdata[CB_RXOVR];
      end
   end

   assign ovr_clr = wr_en & wdata[CB_OVRUN];

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg)); // R7
endmodule

// File: rtl/uhs_rx_hold.sv
module uhs_rx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_strobe,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              ack,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] held,
   output logic              valid,
   output logic              overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held    <= '0;
         valid   <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (rx_strobe) begin
            held  <= rx_byte;
            valid <= 1'b1;
         end else if (ack) begin
            valid <= 1'b0;
         end
         if (rx_strobe && valid && !ack) overrun <= 1'b1;
         else if (ovr_clr)               overrun <= 1'b0;
      end
   end

   AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> (valid && held == $past(rx_byte))); // R2
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !rx_strobe) |=> !valid); // R3
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && valid && !ack) |=> overrun); // R10
   AST_NO_OVR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_strobe && ack && !overrun) |=> !overrun); // R12
endmodule

// File: rtl/uhs_tx_gate.sv
module uhs_tx_gate #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_req,
   input  logic [DATA_W-1:0] wbyte,
   input  logic              tx_done,
   input  logic              cts,
   input  logic              force_rdy,
   output logic              tx_ready,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_byte
);
   logic idle;

   assign tx_ready = idle & (cts | force_rdy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle    <= 1'b1;
         tx_load <= 1'b0;
         tx_byte <= '0;
      end else begin
         tx_load <= 1'b0;
         if (launch_req && tx_ready) begin
            tx_load <= 1'b1;
            tx_byte <= wbyte;
            idle    <= 1'b0;
         end else if (tx_done) begin
            idle    <= 1'b1;
         end
      end
   end

   AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load); // R4
   AST_LOAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_req && tx_ready) |=> (tx_load && tx_byte == $past(wbyte))); // R4
   AST_BUSY_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_req && !tx_ready) |=> !tx_load); // R6
   AST_NO_REQ_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_req |=> !tx_load); // R5
endmodule

// File: rtl/uhs_regs.sv
module uhs_regs
   import uhs_pkg::*;
#(
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter bit          RD_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_load,
   input  logic              tx_done,
   input  logic              tx_cts,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_strobe,
   output logic              rx_rts,
   output logic [1:0]        if_mode
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   generate
      if (BUS_W < MIN_BUS_W) begin : g_bad_bus
         $error("BUS_W too narrow for the control fields");
      end
      if (DATA_W > DB_RXV || DATA_W == 0) begin : g_bad_data
         $error("DATA_W must be 1..8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover two words");
      end
   endgenerate

   logic [WIDX_W-1:0] widx;
   logic hit_data, hit_ctrl, wr_data, wr_ctrl;

   assign widx     = bus_addr[ADDR_W-1:2];
   assign hit_data = bus_sel && (widx == WIDX_W'(WOFS_DATA));
   assign hit_ctrl = bus_sel && (widx == WIDX_W'(WOFS_CTRL));
   assign wr_data  = hit_data && bus_we;
   assign wr_ctrl  = hit_ctrl && bus_we;

   cfg_t cfg;
   logic ovr_clr;
   logic [DATA_W-1:0] held;
   logic valid, overrun, tx_ready;

   uhs_ctrl_reg #(.BUS_W(BUS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
      .cfg(cfg), .ovr_clr(ovr_clr)
   );

   uhs_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
      .ack(wr_data && bus_wdata[DB_RXV]), .ovr_clr(ovr_clr),
      .held(held), .valid(valid), .overrun(overrun)
   );

   uhs_tx_gate #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .launch_req(wr_data && bus_wdata[DB_TXR]),
      .wbyte(bus_wdata[DATA_W-1:0]), .tx_done(tx_done),
      .cts(tx_cts), .force_rdy(cfg.tx_force),
      .tx_ready(tx_ready), .tx_load(tx_load), .tx_byte(tx_byte)
   );

   assign rx_rts  = ~valid | cfg.rx_force;
   assign if_mode = cfg.role;

   logic [BUS_W-1:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (hit_data) begin
         rd_next[DATA_W-1:0] = held;
         rd_next[DB_RXV]     = valid;
         rd_next[DB_TXR]     = tx_ready;
      end else if (hit_ctrl) begin
         rd_next[CB_MODE +: 2] = cfg.role;
         rd_next[CB_TXOVR]     = cfg.tx_force;
         rd_next[CB_RXOVR]     = cfg.rx_force;
         rd_next[CB_OVRUN]     = overrun;
      end
   end

   generate
      if (RD_FLOP) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bus_rdata <= '0;
            else        bus_rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign bus_rdata = rd_next;
         AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !hit_data && !hit_ctrl) |-> (bus_rdata == '0)); // R13
      end
   endgenerate

   AST_RTS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid) |-> rx_rts); // R9
   AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && bus_wdata[DB_RXV] && bus_wdata[DB_TXR] && tx_ready && !rx_strobe)
      |=> (!valid && tx_load)); // R11
endmodule

// File: tb/tb_uhs_regs.sv
`timescale 1ns/100ps
module tb_uhs_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 0, bus_we = 0;
   logic [3:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic [7:0]  tx_byte, rx_byte = 0;
   logic        tx_load, tx_done = 0, tx_cts = 1, rx_strobe = 0, rx_rts;
   logic [1:0]  if_mode;

   uhs_regs dut (.*);

   always #2.5 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   // bench model
   logic       m_valid, m_idle, m_ovr, m_o7, m_o8;
   logic [7:0] m_byte;
   logic [1:0] m_mode;
   logic       got_load;
   logic [7:0] got_byte;

   function automatic logic m_ready();
      return m_idle & (tx_cts | m_o7);
   endfunction
   function automatic logic [31:0] exp_data();
      return {22'd0, m_ready(), m_valid, m_byte};
   endfunction
   function automatic logic [31:0] exp_ctrl();
      return {19'd0, m_ovr, 3'd0, m_o8, m_o7, 3'd0, m_mode, 2'd0};
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #0.5 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d, logic strobe = 0, logic [7:0] sb = 0);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      rx_strobe = strobe; rx_byte = sb;
      @(negedge clk);
      got_load = tx_load; got_byte = tx_byte;
      bus_sel = 0; bus_we = 0; rx_strobe = 0;
   endtask

   task automatic strobe(logic [7:0] b);
      @(negedge clk);
      rx_strobe = 1; rx_byte = b;
      @(negedge clk);
      rx_strobe = 0;
   endtask

   task automatic done_pulse();
      @(negedge clk); tx_done = 1;
      @(negedge clk); tx_done = 0;
   endtask

   // model updates
   task automatic m_strobe(logic [7:0] b, logic ack);
      if (m_valid && !ack) m_ovr = 1;
      m_valid = 1; m_byte = b;
   endtask

   task automatic do_data_wr(string tag, logic [31:0] d);
      logic exp_l;
      exp_l = d[9] && m_ready();
      wr(4'h0, d);
      if (d[8]) m_valid = 0;
      chk({tag, " load"}, {31'd0, got_load}, {31'd0, exp_l});
      if (exp_l) begin
         chk({tag, " byte"}, {24'd0, got_byte}, {24'd0, d[7:0]});
         m_idle = 0;
      end
   endtask

   task automatic do_ctrl_wr(logic [31:0] d);
      wr(4'h4, d);
      m_mode = d[3:2]; m_o7 = d[7]; m_o8 = d[8];
      if (d[12]) m_ovr = 0;
   endtask

   task automatic check_all(string tag);
      logic [31:0] r;
      rd(4'h0, r); chk({tag, " data"}, r, exp_data());
      rd(4'h4, r); chk({tag, " ctrl"}, r, exp_ctrl());
      chk({tag, " rts R9"}, {31'd0, rx_rts}, {31'd0, ~m_valid | m_o8});
      chk({tag, " mode R7"}, {30'd0, if_mode}, {30'd0, m_mode});
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int unsigned seed;
      seed = 32'd4242;
      void'($urandom(seed));
      m_valid = 0; m_idle = 1; m_ovr = 0; m_o7 = 0; m_o8 = 0; m_byte = 0; m_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check_all("R1");
      chk("R1 load", {31'd0, tx_load}, 32'd0);
      // R2 receive capture
      strobe(8'hA5); m_strobe(8'hA5, 0); check_all("R2");
      // R3 bit8 = 0 has no effect, bit8 = 1 acknowledges
      do_data_wr("R3 noack", 32'h0000_00FF); check_all("R3 noack");
      do_data_wr("R3 ack", 32'h0000_0100); check_all("R3 ack");
      // R5 write without bit9
      do_data_wr("R5", 32'h0000_003C); check_all("R5");
      // R4 launch, ready drops
      do_data_wr("R4", 32'h0000_025A); check_all("R4 busy");
      // R6 launch while busy
      do_data_wr("R6", 32'h0000_0211); check_all("R6");
      done_pulse(); m_idle = 1; check_all("R4 done");
      // R8 cts low blocks, override restores
      tx_cts = 0; check_all("R8 cts0");
      do_data_wr("R8 blocked", 32'h0000_0277);
      do_ctrl_wr(32'h0000_0088); check_all("R8 force R7");
      do_data_wr("R8 forced", 32'h0000_0277);
      done_pulse(); m_idle = 1;
      tx_cts = 1;
      // R7 other ctrl bits read 0
      do_ctrl_wr(32'hFFFF_EE74); check_all("R7 mask");
      do_ctrl_wr(32'h0000_0004); check_all("R7 dte");
      // R10 overrun and clear
      strobe(8'h11); m_strobe(8'h11, 0);
      strobe(8'h22); m_strobe(8'h22, 0); check_all("R10 set");
      do_ctrl_wr(32'h0000_1008); check_all("R10 clr");
      // R12 ack with strobe same cycle
      wr(4'h0, 32'h0000_0100, 1, 8'h33); m_strobe(8'h33, 1); check_all("R12");
      // R11 both bits
      do_data_wr("R11", 32'h0000_03C3); check_all("R11");
      done_pulse(); m_idle = 1;
      // R13 unmapped offsets
      wr(4'h8, 32'hFFFF_FFFF); chk("R13 load", {31'd0, got_load}, 32'd0);
      rd(4'h8, r); chk("R13 rd8", r, 32'd0);
      rd(4'hC, r); chk("R13 rdC", r, 32'd0);
      check_all("R13 state");
      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned op;
         op = $urandom_range(0, 5);
         case (op)
            0: begin
                  logic [7:0] b; b = 8'($urandom);
                  strobe(b); m_strobe(b, 0);
               end
            1: do_data_wr("R4 rnd", {22'd0, 2'($urandom), 8'($urandom)});
            2: do_ctrl_wr({19'd0, 1'($urandom), 3'd0, 2'($urandom), 3'd0, 2'($urandom), 2'd0});
            3: begin done_pulse(); m_idle = 1; end
            4: begin @(negedge clk); tx_cts = 1'($urandom); end
            default: check_all("R2 rnd");
         endcase
      end
      check_all("R10 final");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule